// File: doc/BRIEF.md
# SPI flash opcode-menu sequencer

This block is a software-sequenced SPI flash host. Firmware fills a table of eight command entries (an opcode byte plus an attribute nibble holding the entry's type and clock-rate code). It also fills two prefix opcodes and a 64-byte data buffer, all through a byte-wide register port. A transfer is launched by pulsing `start` with a menu index, a prefix select, an atomic flag, a data-phase flag, a direction, a 24-bit address and a byte count. The sequencer then runs one SPI frame in mode 0. For an atomic request it runs two frames back to back: the prefix byte alone, then the main command.

The entry's type decides whether address bytes follow the opcode and which data direction is legal. The rate code picks the SCK half-period as a count of system clocks. Received bytes land in the data buffer, where firmware reads them back. A lock bit, once set, freezes the command table until reset. Any attempt to write the table after that raises a sticky access-denied flag.

Top module: `spiseq_top`

## Requirements
- R1: After reset `cs_n` is 1, `sck`, `mosi`, `busy`, `done` and all four error flags are 0, and every table register (0x40..0x51) and the lock/status register (0x52) read 0.
- R2: Register map on `reg_addr`: 0x00..0x3F data buffer bytes, 0x40+i opcode of entry i, 0x48+i attributes of entry i (bits 1:0 type, bits 3:2 rate code, upper bits read 0), 0x50/0x51 prefix 0/1, 0x52 status (bit0 lock, bit1 access-denied). Written values read back on `reg_rdata` in the same cycle the address is applied.
- R3: A main frame sends, MSB first in SPI mode 0 (SCK idle low, MOSI stable across each rising SCK edge, MISO sampled on the rising edge), the opcode, then for types 2 and 3 the three address bytes, most significant first, then the data phase if `data_en` is set; types 0 and 1 send no address.
- R4: With `data_en`=1 and `dir_out`=1 (types 1 and 3), data bytes buffer[0..n-1] follow the header in order, for any n from 1 to 64.
- R5: With `data_en`=1 and `dir_out`=0 (types 0 and 2), n bytes are clocked in and stored at buffer[0..n-1]; MOSI sends 0x00 during those bytes.
- R6: With `atomic`=1, the prefix selected by `pfx_idx` is sent as a one-byte frame, `cs_n` returns high for at least two SCK half-periods, and the main frame follows with no other frame between them.
- R7: Rate codes 0, 1 and 3 give SCK high times of HALF_R0, HALF_R1 and HALF_R3 system clocks. An entry with rate code 2 is rejected: `err_rate` is set and `cs_n` stays high.
- R8: A menu index of 8 or more (0xFF included) sets `err_unsup` and no frame is sent.
- R9: With `data_en`=1, a byte count of 0 or above 64, or `dir_out` different from type bit 0, sets `err_param` and no frame is sent.
- R10: Writing 1 to status bit0 locks the table. Later writes to 0x40..0x52 leave every table value and the lock unchanged and set `err_denied`. Only reset clears lock and `err_denied`.
- R11: `busy` is 1 from the cycle after an accepted start until one cycle after `cs_n` returns high; `done` pulses for exactly one cycle per accepted request; `start` while busy is ignored.
- R12: `err_unsup`, `err_rate` and `err_param` reflect the most recent start taken while idle and are cleared by an accepted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register port write strobe |
| reg_addr | input | 8 | Register port address |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Register port read data (combinational) |
| start | input | 1 | Request a transfer |
| op_idx | input | 8 | Command menu index |
| pfx_idx | input | 1 | Prefix select for atomic requests |
| atomic | input | 1 | Send prefix frame first |
| data_en | input | 1 | Request has a data phase |
| dir_out | input | 1 | 1 shifts buffer out, 0 fills buffer |
| addr | input | 24 | Flash address for addressed types |
| byte_cnt | input | 7 | Data phase length |
| sck | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err_unsup | output | 1 | Last request used an unsupported index |
| err_rate | output | 1 | Last request used the reserved rate code |
| err_param | output | 1 | Last request had an invalid count or direction |
| err_denied | output | 1 | A write hit the locked table |

## Verification
The hardest condition to reach from the ports is a start request that arrives during the idle gap between the prefix frame and the main command of an atomic request. In that window `cs_n` is high, so an external master would see an idle bus. The stimulus keeps pulsing valid starts every few cycles for the whole of an atomic transfer, so some of them land in that gap, and then checks that exactly two frames with the expected bytes appeared. Randomized menus, rates, counts and directions are mixed with directed runs at 64 bytes and at every rejection rule.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;
  typedef enum logic [1:0] {
    TY_RD_NOADDR = 2'd0,
    TY_WR_NOADDR = 2'd1,
    TY_RD_ADDR   = 2'd2,
    TY_WR_ADDR   = 2'd3
  } cmd_type_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PFX,
    ST_GAP,
    ST_MAIN,
    ST_END
  } seq_state_e;

  localparam logic [7:0] A_MENU_OP = 8'h40;
  localparam logic [7:0] A_MENU_AT = 8'h48;
  localparam logic [7:0] A_PFX     = 8'h50;
  localparam logic [7:0] A_STATUS  = 8'h52;
  localparam logic [1:0] RATE_RSVD = 2'd2;
endpackage

// File: rtl/spiseq_cfg.sv
module spiseq_cfg
  import spiseq_pkg::*;
#(
  parameter int NUM_OP  = 8,
  parameter int NUM_PFX = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [7:0]              addr,
  input  logic [7:0]              wdata,
  output logic [NUM_OP-1:0][7:0]  menu_op,
  output logic [NUM_OP-1:0][3:0]  menu_at,
  output logic [NUM_PFX-1:0][7:0] pfx_op,
  output logic                    locked,
  output logic                    denied
);
  logic [NUM_OP-1:0]  op_en;
  logic [NUM_OP-1:0]  at_en;
  logic [NUM_PFX-1:0] pf_en;
  logic open_wr, cfg_hit, lock_d, denied_d;

  assign open_wr = we && !locked;
  assign cfg_hit = we && (addr >= A_MENU_OP) && (addr <= A_STATUS);

  for (genvar g = 0; g < NUM_OP; g++) begin : g_menu_en
    assign op_en[g] = open_wr && (addr == A_MENU_OP + 8'(g));
    assign at_en[g] = open_wr && (addr == A_MENU_AT + 8'(g));
  end
  for (genvar g = 0; g < NUM_PFX; g++) begin : g_pfx_en
    assign pf_en[g] = open_wr && (addr == A_PFX + 8'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      menu_op <= '0;
      menu_at <= '0;
      pfx_op  <= '0;
    end else begin
      for (int i = 0; i < NUM_OP; i++) begin
        if (op_en[i]) menu_op[i] <= wdata;
        if (at_en[i]) menu_at[i] <= wdata[3:0];
      end
      for (int i = 0; i < NUM_PFX; i++) begin
        if (pf_en[i]) pfx_op[i] <= wdata;
      end
    end
  end

  always_comb begin
    lock_d   = locked | (open_wr && (addr == A_STATUS) && wdata[0]);
    denied_d = denied | (we && locked && cfg_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      denied <= 1'b0;
    end else begin
      locked <= lock_d;
      denied <= denied_d;
    end
  end

  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  a_r10_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && we) |=> ($stable(menu_op) && $stable(menu_at) && $stable(pfx_op)));
endmodule

// File: rtl/spiseq_shift.sv
module spiseq_shift #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic             load,
  input  logic [7:0]       tx_byte,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             byte_done,
  output logic [7:0]       rx_byte
);
  logic             act_q, act_d;
  logic             sck_q, sck_d;
  logic [7:0]       sh_q, sh_d;
  logic [7:0]       rx_q, rx_d;
  logic [2:0]       bit_q, bit_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             bd_d, bd_q;
  logic             tick;

  assign tick = act_q && (cnt_q == half_div - DIV_W'(1));

  always_comb begin
    act_d = act_q;
    sck_d = sck_q;
    sh_d  = sh_q;
    rx_d  = rx_q;
    bit_d = bit_q;
    cnt_d = cnt_q;
    bd_d  = 1'b0;
    if (load) begin
      act_d = 1'b1;
      sck_d = 1'b0;
      sh_d  = tx_byte;
      bit_d = '0;
      cnt_d = '0;
    end else if (act_q) begin
      if (tick) begin
        cnt_d = '0;
        if (!sck_q) begin
          sck_d = 1'b1;
          rx_d  = {rx_q[6:0], miso};
        end else begin
          sck_d = 1'b0;
          if (bit_q == 3'd7) begin
            act_d = 1'b0;
            bd_d  = 1'b1;
          end else begin
            sh_d  = {sh_q[6:0], 1'b0};
            bit_d = bit_q + 3'd1;
          end
        end
      end else begin
        cnt_d = cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sck_q <= 1'b0;
      sh_q  <= '0;
      rx_q  <= '0;
      bit_q <= '0;
      cnt_q <= '0;
      bd_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      sck_q <= sck_d;
      sh_q  <= sh_d;
      rx_q  <= rx_d;
      bit_q <= bit_d;
      cnt_q <= cnt_d;
      bd_q  <= bd_d;
    end
  end

  assign sck       = sck_q;
  assign mosi      = act_q ? sh_q[7] : 1'b0;
  assign byte_done = bd_q;
  assign rx_byte   = rx_q;

  a_r3_mosi_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_q) |-> $stable(mosi));
  a_r3_eight_rises_per_byte: assert property (@(posedge clk) disable iff (!rst_n)
    bd_q |-> !act_q);
endmodule

// File: rtl/spiseq_top.sv
module spiseq_top
  import spiseq_pkg::*;
#(
  parameter int NUM_OP    = 8,
  parameter int NUM_PFX   = 2,
  parameter int BUF_DEPTH = 64,
  parameter int ADDR_W    = 24,
  parameter int DIV_W     = 4,
  parameter int HALF_R0   = 3,
  parameter int HALF_R1   = 2,
  parameter int HALF_R3   = 1,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1),
  localparam int PFX_W    = (NUM_PFX > 1) ? $clog2(NUM_PFX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              start,
  input  logic [7:0]        op_idx,
  input  logic [PFX_W-1:0]  pfx_idx,
  input  logic              atomic,
  input  logic              data_en,
  input  logic              dir_out,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  byte_cnt,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              err_unsup,
  output logic              err_rate,
  output logic              err_param,
  output logic              err_denied
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int IDX_W      = $clog2(NUM_OP);
  localparam int BUF_AW     = $clog2(BUF_DEPTH);
  localparam int SEQ_W      = $clog2(BUF_DEPTH + ADDR_BYTES + 1);
  localparam int HDR_W      = $clog2(ADDR_BYTES + 2);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  // configuration table
  logic [NUM_OP-1:0][7:0]  menu_op;
  logic [NUM_OP-1:0][3:0]  menu_at;
  logic [NUM_PFX-1:0][7:0] pfx_op;
  logic                    locked;

  spiseq_cfg #(.NUM_OP(NUM_OP), .NUM_PFX(NUM_PFX)) cfg_i (
    .clk(clk), .rst_n(rst_sn), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .menu_op(menu_op), .menu_at(menu_at), .pfx_op(pfx_op),
    .locked(locked), .denied(err_denied)
  );

  // sequencer state
  seq_state_e         state_q, state_d;
  logic               cs_q, cs_d;
  logic               kick_q, kick_d;
  logic [SEQ_W-1:0]   seq_q, seq_d;
  logic [DIV_W:0]     gap_q, gap_d;
  logic [2:0]         eflg_q, eflg_d;

  logic [7:0]         cur_opc, cur_pfb;
  logic [1:0]         cur_ty;
  logic [DIV_W-1:0]   cur_half;
  logic               cur_data, cur_dir;
  logic [ADDR_W-1:0]  cur_addr;
  logic [HDR_W-1:0]   cur_hdr;
  logic [SEQ_W-1:0]   cur_last;

  logic [7:0]         dbuf [BUF_DEPTH];

  // request evaluation
  logic               idx_ok, rate_bad, param_bad, take, accept;
  logic [IDX_W-1:0]   ent;
  logic [3:0]         sel_at;
  logic [HDR_W-1:0]   new_hdr;
  logic [SEQ_W-1:0]   new_last;
  logic [DIV_W-1:0]   new_half;

  always_comb begin
    idx_ok    = (int'(op_idx) < NUM_OP);
    ent       = op_idx[IDX_W-1:0];
    sel_at    = menu_at[ent];
    rate_bad  = idx_ok && (sel_at[3:2] == RATE_RSVD);
    param_bad = idx_ok && data_en &&
                ((byte_cnt == '0) || (int'(byte_cnt) > BUF_DEPTH) || (dir_out != sel_at[0]));
    take      = start && (state_q == ST_IDLE);
    accept    = take && idx_ok && !rate_bad && !param_bad;
    new_hdr   = sel_at[1] ? HDR_W'(1 + ADDR_BYTES) : HDR_W'(1);
    new_last  = SEQ_W'(new_hdr) - SEQ_W'(1) + (data_en ? SEQ_W'(byte_cnt) : '0);
    case (sel_at[3:2])
      2'd0:    new_half = DIV_W'(HALF_R0);
      2'd1:    new_half = DIV_W'(HALF_R1);
      default: new_half = DIV_W'(HALF_R3);
    endcase
  end

  // shift engine
  logic       sh_load, byte_done;
  logic [7:0] tx_byte, rx_byte;

  assign sh_load = kick_q;

  spiseq_shift #(.DIV_W(DIV_W)) shift_i (
    .clk(clk), .rst_n(rst_sn), .half_div(cur_half), .load(sh_load),
    .tx_byte(tx_byte), .miso(miso), .sck(sck), .mosi(mosi),
    .byte_done(byte_done), .rx_byte(rx_byte)
  );

  // outgoing byte selection
  logic [SEQ_W-1:0]  didx;
  logic [ADDR_W-1:0] addr_sh;
  always_comb begin
    tx_byte = 8'h00;
    didx    = seq_q - SEQ_W'(cur_hdr);
    addr_sh = cur_addr >> (8 * (ADDR_BYTES - int'(seq_q)));
    if (state_q == ST_PFX)                tx_byte = cur_pfb;
    else if (seq_q == '0)                 tx_byte = cur_opc;
    else if (seq_q < SEQ_W'(cur_hdr))     tx_byte = addr_sh[7:0];
    else if (cur_dir)                     tx_byte = dbuf[didx[BUF_AW-1:0]];
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    cs_d    = cs_q;
    kick_d  = 1'b0;
    seq_d   = seq_q;
    gap_d   = gap_q;
    eflg_d  = eflg_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take) eflg_d = {param_bad, rate_bad, !idx_ok};
        if (accept) begin
          cs_d    = 1'b0;
          kick_d  = 1'b1;
          seq_d   = '0;
          state_d = atomic ? ST_PFX : ST_MAIN;
        end
      end
      ST_PFX: begin
        if (byte_done) begin
          cs_d    = 1'b1;
          gap_d   = '0;
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        gap_d = gap_q + (DIV_W+1)'(1);
        if (gap_q >= {cur_half, 1'b0} - (DIV_W+1)'(1)) begin
          cs_d    = 1'b0;
          kick_d  = 1'b1;
          state_d = ST_MAIN;
        end
      end
      ST_MAIN: begin
        if (byte_done) begin
          if (seq_q == cur_last) begin
            cs_d    = 1'b1;
            state_d = ST_END;
          end else begin
            seq_d  = seq_q + SEQ_W'(1);
            kick_d = 1'b1;
          end
        end
      end
      ST_END:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b1;
      kick_q  <= 1'b0;
      seq_q   <= '0;
      gap_q   <= '0;
      eflg_q  <= '0;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_d;
      kick_q  <= kick_d;
      seq_q   <= seq_d;
      gap_q   <= gap_d;
      eflg_q  <= eflg_d;
    end
  end

  // request capture, enabled by accept
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cur_opc  <= '0;
      cur_pfb  <= '0;
      cur_ty   <= '0;
      cur_half <= DIV_W'(1);
      cur_data <= 1'b0;
      cur_dir  <= 1'b0;
      cur_addr <= '0;
      cur_hdr  <= HDR_W'(1);
      cur_last <= '0;
    end else if (accept) begin
      cur_opc  <= menu_op[ent];
      cur_pfb  <= pfx_op[pfx_idx];
      cur_ty   <= sel_at[1:0];
      cur_half <= new_half;
      cur_data <= data_en;
      cur_dir  <= dir_out;
      cur_addr <= addr;
      cur_hdr  <= new_hdr;
      cur_last <= new_last;
    end
  end

  // data buffer: engine fills on reads, port writes only while idle
  logic eng_we, port_we;
  assign eng_we  = (state_q == ST_MAIN) && byte_done && cur_data && !cur_dir &&
                   (seq_q >= SEQ_W'(cur_hdr));
  assign port_we = reg_we && (int'(reg_addr) < BUF_DEPTH) && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (eng_we)       dbuf[didx[BUF_AW-1:0]]    <= rx_byte;
    else if (port_we) dbuf[reg_addr[BUF_AW-1:0]] <= reg_wdata;
  end

  // register read port
  always_comb begin
    reg_rdata = 8'h00;
    if (int'(reg_addr) < BUF_DEPTH)
      reg_rdata = dbuf[reg_addr[BUF_AW-1:0]];
    else if (reg_addr >= A_MENU_OP && reg_addr < A_MENU_OP + 8'(NUM_OP))
      reg_rdata = menu_op[IDX_W'(reg_addr - A_MENU_OP)];
    else if (reg_addr >= A_MENU_AT && reg_addr < A_MENU_AT + 8'(NUM_OP))
      reg_rdata = {4'h0, menu_at[IDX_W'(reg_addr - A_MENU_AT)]};
    else if (reg_addr >= A_PFX && reg_addr < A_PFX + 8'(NUM_PFX))
      reg_rdata = pfx_op[PFX_W'(reg_addr - A_PFX)];
    else if (reg_addr == A_STATUS)
      reg_rdata = {6'h00, err_denied, locked};
  end

  assign cs_n      = cs_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_END);
  assign err_unsup = eflg_q[0];
  assign err_rate  = eflg_q[1];
  assign err_param = eflg_q[2];

  a_r6_sck_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_sn)
    cs_n |-> !sck);
  a_r8_bad_index_keeps_cs_high: assert property (@(posedge clk) disable iff (!rst_sn)
    ((state_q == ST_IDLE) && start && (int'(op_idx) >= NUM_OP)) |=> cs_n);
  a_r11_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done);
  a_r11_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && start) |=> ($stable(cur_opc) && $stable(cur_addr) && $stable(cur_last)));
endmodule

// File: tb/spiseq_top_tb_top.sv
`timescale 1ns/1ps
module spiseq_top_tb_top;
  localparam int H0 = 3, H1 = 2, H3 = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
  logic start = 1'b0;
  logic [7:0] op_idx = 8'h00;
  logic pfx_idx = 1'b0, atomic = 1'b0, data_en = 1'b0, dir_out = 1'b0;
  logic [23:0] addr = 24'h0;
  logic [6:0] byte_cnt = 7'd0;
  logic sck, cs_n, mosi, miso, busy, done;
  logic err_unsup, err_rate, err_param, err_denied;

  always #5 clk = ~clk;

  spiseq_top #(.HALF_R0(H0), .HALF_R1(H1), .HALF_R3(H3)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start(start), .op_idx(op_idx),
    .pfx_idx(pfx_idx), .atomic(atomic), .data_en(data_en), .dir_out(dir_out),
    .addr(addr), .byte_cnt(byte_cnt), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .busy(busy), .done(done), .err_unsup(err_unsup),
    .err_rate(err_rate), .err_param(err_param), .err_denied(err_denied)
  );

  int nchk = 0, nfail = 0;

  // behavioural flash responder
  logic [7:0] fb [0:3][0:79];
  int fl [0:3];
  int nf_tot = 0, rbit = 0, rlen = 0;
  logic [7:0] rsh = 8'h00;
  logic cs_prev = 1'b1, sck_prev = 1'b0;
  realtime t_rise = 0, hw = 0, t_csr = 0, gap_t = 0;

  function automatic logic [7:0] resp(input int k);
    return 8'h3C ^ 8'(k * 29);
  endfunction
  function automatic logic resp_bit(input int k, input int b);
    logic [7:0] v;
    v = resp(k);
    return v[3'(7 - b)];
  endfunction

  assign miso = cs_n ? 1'b0 : resp_bit(rlen, rbit);

  always @(sck or cs_n) begin
    if (cs_n !== cs_prev) begin
      if (cs_n === 1'b0) begin
        rbit = 0; rlen = 0; gap_t = $realtime - t_csr;
      end else begin
        fl[nf_tot % 4] = rlen; nf_tot++; t_csr = $realtime;
      end
    end else if (sck !== sck_prev) begin
      if (sck === 1'b1) begin
        rsh = {rsh[6:0], mosi};
        rbit++;
        if (rbit == 8) begin
          if (rlen < 80) fb[nf_tot % 4][rlen] = rsh;
          rlen++; rbit = 0;
        end
        t_rise = $realtime;
      end else begin
        hw = $realtime - t_rise;
      end
    end
    cs_prev = cs_n; sck_prev = sck;
  end

  int ndone = 0;
  always @(posedge clk) if (done === 1'b1) ndone++;

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk + 1, nfail + 1);
      $finish;
    end
  end

  // bench mirrors of configuration and buffer
  logic [7:0] m_op [0:7];
  logic [3:0] m_at [0:7];
  logic [7:0] m_pf [0:1];
  logic [7:0] bb [0:63];
  bit m_lock = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a < 8'h40) bb[a[5:0]] = d;
    else if (!m_lock) begin
      if (a < 8'h48) m_op[a[2:0]] = d;
      else if (a < 8'h50) m_at[a[2:0]] = d[3:0];
      else if (a < 8'h52) m_pf[a[0]] = d;
      else if (a == 8'h52 && d[0]) m_lock = 1;
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic go(input logic [7:0] op, input bit p, input bit at, input bit de,
                    input bit dir, input logic [23:0] ad, input int cnt);
    @(negedge clk);
    op_idx = op; pfx_idx = p; atomic = at; data_en = de; dir_out = dir;
    addr = ad; byte_cnt = 7'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle;
    int n = 0;
    while (busy && n < 30000) begin
      @(negedge clk); n++;
    end
    @(negedge clk);
  endtask

  // check one accepted request against the bench model
  task automatic check_run(input string tag, input int op, input bit p, input bit at,
                           input bit de, input bit dir, input logic [23:0] ad, input int cnt,
                           input int base_nf, input int base_done);
    int hdr, len, ms, bad;
    logic [7:0] ex, got;
    hdr = m_at[op][1] ? 4 : 1;
    len = hdr + (de ? cnt : 0);
    chk({tag, " frame count"}, nf_tot - base_nf, at ? 2 : 1);
    chk({tag, " R11 done pulses"}, ndone - base_done, 1);
    if (at) begin
      chk({tag, " R6 prefix len"}, fl[base_nf % 4], 1);
      chk({tag, " R6 prefix byte"}, fb[base_nf % 4][0], m_pf[p]);
      chk({tag, " R6 gap"}, (gap_t >= 2 * 10 * ((m_at[op][3:2] == 0) ? H0 :
                                  (m_at[op][3:2] == 1) ? H1 : H3)) ? 1 : 0, 1);
    end
    ms = (base_nf + (at ? 1 : 0)) % 4;
    chk({tag, " R3 frame len"}, fl[ms], len);
    bad = 0;
    for (int k = 0; k < len && k < 80; k++) begin
      if (k == 0) ex = m_op[op];
      else if (k < hdr) ex = ad[8 * (3 - k) +: 8];
      else if (dir) ex = bb[k - hdr];
      else ex = 8'h00;
      if (fb[ms][k] !== ex) begin
        if (bad == 0) chk({tag, " R3 R4 R5 byte"}, fb[ms][k], ex);
        bad++;
      end
    end
    if (bad == 0) chk({tag, " R3 R4 bytes"}, 0, 0);
    if (de && !dir) begin
      bad = 0;
      for (int i = 0; i < cnt; i++) begin
        rd(8'(i), got);
        bb[i] = resp(hdr + i);
        if (got !== bb[i] && bad == 0) begin
          chk({tag, " R5 buffer"}, got, bb[i]); bad++;
        end
      end
      if (bad == 0) chk({tag, " R5 buffer"}, 0, 0);
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_lock = 0;
    for (int i = 0; i < 8; i++) begin m_op[i] = 0; m_at[i] = 0; end
    m_pf[0] = 0; m_pf[1] = 0;
  endtask

  task automatic expect_reject(input string tag, input logic [7:0] op, input bit de,
                               input bit dir, input int cnt, input bit eu, input bit er,
                               input bit ep);
    int b;
    b = nf_tot;
    go(op, 0, 0, de, dir, 24'h0, cnt);
    repeat (6) @(negedge clk);
    chk({tag, " no frame"}, nf_tot - b, 0);
    chk({tag, " cs_n high"}, cs_n, 1);
    chk({tag, " flags"}, {err_unsup, err_rate, err_param}, {eu, er, ep});
  endtask

  initial begin
    logic [7:0] v;
    int bnf, bd, op, cnt, seedv;
    bit at, de, dir, p;
    logic [23:0] ad;
    seedv = $urandom(32'h5EED_0042);

    do_reset;
    // R1 reset state
    chk("R1 cs_n", cs_n, 1);
    chk("R1 sck/mosi", {sck, mosi}, 0);
    chk("R1 busy/done", {busy, done}, 0);
    chk("R1 flags", {err_unsup, err_rate, err_param, err_denied}, 0);
    rd(8'h40, v); chk("R1 menu reg", v, 0);
    rd(8'h52, v); chk("R1 status reg", v, 0);

    // R2 program and read back
    wr(8'h40, 8'h02); wr(8'h48, 4'b1111);  // type 3, rate 3
    wr(8'h41, 8'h03); wr(8'h49, 4'b0110);  // type 2, rate 1
    wr(8'h42, 8'h9F); wr(8'h4A, 4'b0000);  // type 0, rate 0
    wr(8'h43, 8'h06); wr(8'h4B, 4'b1101);  // type 1, rate 3
    wr(8'h44, 8'h20); wr(8'h4C, 4'b1011);  // reserved rate
    for (int i = 5; i < 8; i++) begin wr(8'(8'h40 + i), 8'(8'h10 + i)); wr(8'(8'h48 + i), 4'b0100); end
    wr(8'h50, 8'h06); wr(8'h51, 8'h50);
    rd(8'h41, v); chk("R2 opcode readback", v, 8'h03);
    rd(8'h49, v); chk("R2 attr readback", v, 8'h06);
    rd(8'h51, v); chk("R2 prefix readback", v, 8'h50);
    for (int i = 0; i < 64; i++) wr(8'(i), 8'(i * 7 + 1));
    rd(8'h3F, v); chk("R2 buffer readback", v, bb[63]);

    // R3/R4 addressed write, R11 busy
    bnf = nf_tot; bd = ndone;
    go(8'd0, 0, 0, 1, 1, 24'h123456, 4);
    chk("R11 busy after start", busy, 1);
    wait_idle;
    chk("R11 busy cleared", busy, 0);
    check_run("w4", 0, 0, 0, 1, 1, 24'h123456, 4, bnf, bd);
    chk("R7 rate3 sck high", int'(hw), 10 * H3);

    // R5 addressed read
    bnf = nf_tot; bd = ndone;
    go(8'd1, 0, 0, 1, 0, 24'hA1B2C3, 8); wait_idle;
    check_run("r8", 1, 0, 0, 1, 0, 24'hA1B2C3, 8, bnf, bd);
    chk("R7 rate1 sck high", int'(hw), 10 * H1);

    // no-address read, rate 0
    bnf = nf_tot; bd = ndone;
    go(8'd2, 0, 0, 1, 0, 24'h0, 3); wait_idle;
    check_run("id3", 2, 0, 0, 1, 0, 24'h0, 3, bnf, bd);
    chk("R7 rate0 sck high", int'(hw), 10 * H0);

    // R6 atomic with R11 starts while busy (some land in the gap)
    bnf = nf_tot; bd = ndone;
    go(8'd0, 1, 1, 1, 1, 24'h00FF10, 2);
    while (busy) begin
      op_idx = 8'd3; atomic = 1'b0; data_en = 1'b0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (2) @(negedge clk);
    end
    wait_idle;
    check_run("R6 R11 atomic", 0, 1, 1, 1, 1, 24'h00FF10, 2, bnf, bd);

    // R7 reserved rate, R8 unsupported, R9 parameters, R12 refresh
    expect_reject("R7 rsvd rate", 8'd4, 0, 0, 0, 0, 1, 0);
    expect_reject("R8 idx FF", 8'hFF, 0, 0, 0, 1, 0, 0);
    expect_reject("R8 idx 8", 8'd8, 0, 0, 0, 1, 0, 0);
    expect_reject("R9 cnt 0", 8'd0, 1, 1, 0, 0, 0, 1);
    expect_reject("R9 cnt 65", 8'd0, 1, 1, 65, 0, 0, 1);
    expect_reject("R9 dir mismatch", 8'd1, 1, 1, 4, 0, 0, 1);
    bnf = nf_tot; bd = ndone;
    go(8'd3, 0, 0, 0, 1, 24'h0, 0); wait_idle;
    check_run("wren", 3, 0, 0, 0, 1, 24'h0, 0, bnf, bd);
    chk("R12 flags cleared", {err_unsup, err_rate, err_param}, 0);

    // R4/R5 boundary: 64 bytes each way
    bnf = nf_tot; bd = ndone;
    go(8'd0, 0, 0, 1, 1, 24'h000100, 64); wait_idle;
    check_run("R4 w64", 0, 0, 0, 1, 1, 24'h000100, 64, bnf, bd);
    wr(8'h49, 4'b1110);
    bnf = nf_tot; bd = ndone;
    go(8'd1, 0, 0, 1, 0, 24'h7FFFFF, 64); wait_idle;
    check_run("R5 r64", 1, 0, 0, 1, 0, 24'h7FFFFF, 64, bnf, bd);

    // constrained random
    for (int it = 0; it < 24; it++) begin
      int rt;
      op = 5 + ($urandom % 3);
      rt = $urandom % 3; if (rt == 2) rt = 3;
      wr(8'(8'h40 + op), 8'($urandom));
      wr(8'(8'h48 + op), 8'({rt[1:0], 2'($urandom)}));
      wr(8'h50, 8'($urandom));
      de  = $urandom % 4 != 0;
      dir = m_at[op][0];
      cnt = de ? 1 + ($urandom % 12) : 0;
      at  = $urandom % 3 == 0;
      p   = 1'($urandom);
      ad  = 24'($urandom);
      if (dir) for (int i = 0; i < cnt; i++) wr(8'(i), 8'($urandom));
      bnf = nf_tot; bd = ndone;
      go(8'(op), p, at, de, dir, ad, cnt); wait_idle;
      check_run("rand R3 R4 R5 R6", op, p, at, de, dir, ad, cnt, bnf, bd);
    end

    // R10 lock
    wr(8'h52, 8'h01);
    rd(8'h52, v); chk("R10 lock set", v, 8'h01);
    wr(8'h40, 8'hEE); wr(8'h50, 8'hEE); wr(8'h52, 8'h00);
    rd(8'h40, v); chk("R10 opcode frozen", v, m_op[0]);
    rd(8'h50, v); chk("R10 prefix frozen", v, m_pf[0]);
    rd(8'h52, v); chk("R10 lock and denied", v, 8'h03);
    chk("R10 denied flag", err_denied, 1);
    bnf = nf_tot; bd = ndone;
    go(8'd3, 0, 0, 0, 1, 24'h0, 0); wait_idle;
    check_run("R10 locked run", 3, 0, 0, 0, 1, 24'h0, 0, bnf, bd);
    do_reset;
    rd(8'h52, v); chk("R10 reset clears lock", v, 8'h00);
    chk("R10 reset clears denied", err_denied, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule